// File: doc/BRIEF.md
# Virtual Interrupt Routing and Masking Unit

This block sits beside a core's exception-entry logic and decides, each clock, whether one of three interrupt classes (IRQ, FIQ, SError) should be taken, whether the winner is physical or virtual, and which exception level receives it. It takes the current exception level, the three processor mask bits, one hypervisor routing bit per class, a host-mode bit and a host-extension enable bit. It also takes three sets of pending lines: physical interrupts, software-set virtual pending bits, and virtual lines from an external interrupt controller's virtual CPU interface.

The routing bit of a class changes what its mask bit does. With routing clear, the mask gates physical interrupts bound for EL1. With routing set, physical interrupts go to EL2, and below EL2 they ignore the mask. Virtual interrupts of that class become enabled for EL0/EL1, and the mask gates them instead. Host mode at EL0, with the extension enabled, sends every physical interrupt to EL2 and blocks virtual ones.

The decision is registered. The take strobe and its class, kind and target fields appear one clock after the inputs that caused them.

Top module: `vint_router`

## Requirements
- R1: Outputs are registered. The strobe `take_o` and the fields `take_virt_o`, `take_cls_o` and `take_el_o` reflect the inputs sampled at the previous rising edge. When nothing is takeable, all four outputs are 0. Class code 0 is IRQ, 1 is FIQ and 2 is SError. Bit 0, 1 and 2 of every per-class vector belong to IRQ, FIQ and SError respectively. `take_virt_o` is 1 for a virtual interrupt.
- R2: A class has a virtual interrupt pending when its bit in `virt_sw` is 1 or its bit in `virt_ext` is 1.
- R3: A virtual interrupt is taken only while `cur_el` is 0 or 1, and its target is always EL1. At EL2 and EL3 it stays pending and is not taken.
- R4: A pending virtual interrupt is taken only if its class routing bit is 1 and its class mask bit in `pstate_mask` is 0.
- R5: With its routing bit set, a physical interrupt targets EL2. At EL0/EL1 it is taken whatever its mask bit.
- R6: With its routing bit set, a physical interrupt at EL2 is taken only when its mask bit is 0. At EL3 it is not taken.
- R7: With its routing bit clear, a physical interrupt at EL0/EL1 targets EL1 and is taken only when its mask bit is 0. At EL2/EL3 it is not taken.
- R8: When `cur_el` is 0 and both `host_mode` and `vhe_en` are 1, every physical interrupt targets EL2 and is taken whatever its routing and mask bits. No virtual interrupt is taken. With `vhe_en` 0 the routing bits apply as usual.
- R9: When a physical and a virtual interrupt are both takeable, the physical one is reported.
- R10: Among takeable interrupts of the same kind, SError beats FIQ and FIQ beats IRQ.
- R11: An active-low asynchronous reset clears all outputs at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| pstate_mask | input | 3 | Processor mask bits (bit0 I, bit1 F, bit2 A) |
| route_en | input | 3 | Hypervisor routing bit per class |
| host_mode | input | 1 | Host-mode bit (EL0 belongs to the host) |
| vhe_en | input | 1 | Host-extension enable |
| phys_pend | input | 3 | Physical pending lines per class |
| virt_sw | input | 3 | Software-set virtual pending bits per class |
| virt_ext | input | 3 | Virtual lines from the external virtual CPU interface |
| take_o | output | 1 | Take-exception strobe |
| take_virt_o | output | 1 | 1 when the taken interrupt is virtual |
| take_cls_o | output | 2 | Class of the taken interrupt |
| take_el_o | output | 2 | Target exception level |

## Verification
Every result is due exactly one rising edge after the inputs that cause it, because there is a single register stage between the inputs and all four outputs. The bench changes inputs on a falling edge and samples outputs on the next falling edge, so each sample falls after exactly one capturing edge. The same timing shows the strobe dropping in the cycle after its inputs go idle. The reset check is the one exception: it samples a nanosecond after reset falls, because the clear is asynchronous and does not wait for a clock.

// File: rtl/vint_route_pkg.sv
package vint_route_pkg;
   typedef enum logic [1:0] {
      CLS_IRQ  = 2'd0,
      CLS_FIQ  = 2'd1,
      CLS_SERR = 2'd2
   } int_class_e;

   localparam int CLASS_COUNT = 3;
   localparam int EL_BITS     = 2;
endpackage

// File: rtl/vint_class_eval.sv
module vint_class_eval #(
   parameter int EL_W = 2
) (
   input  logic [EL_W-1:0] cur_el,
   input  logic            mask_bit,
   input  logic            route_bit,
   input  logic            host_ovr,
   input  logic            phys,
   input  logic            vpend,
   output logic            phys_take,
   output logic            phys_to_el2,
   output logic            virt_take
);
   logic below_el2;
   logic at_el2;
   logic eff_route;

   always_comb begin
      below_el2   = (cur_el <= EL_W'(1));
      at_el2      = (cur_el == EL_W'(2));
      eff_route   = route_bit | host_ovr;
      phys_to_el2 = eff_route;
      if (eff_route)
         phys_take = phys & (below_el2 | (at_el2 & ~mask_bit));
      else
         phys_take = phys & below_el2 & ~mask_bit;
      virt_take = vpend & below_el2 & route_bit & ~host_ovr & ~mask_bit;
   end
endmodule

// File: rtl/vint_pick.sv
module vint_pick #(
   parameter int NCLS  = 3,
   parameter int EL_W  = 2,
   localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic [NCLS-1:0]  phys_take,
   input  logic [NCLS-1:0]  phys_to_el2,
   input  logic [NCLS-1:0]  virt_take,
   output logic             any_take,
   output logic             is_virt,
   output logic [CLS_W-1:0] cls,
   output logic [EL_W-1:0]  tgt_el
);
   always_comb begin
      any_take = 1'b0;
      is_virt  = 1'b0;
      cls      = '0;
      tgt_el   = '0;
      // later writes override: higher class index, then physical over virtual
      for (int i = 0; i < NCLS; i++) begin
         if (virt_take[i]) begin
            any_take = 1'b1;
            is_virt  = 1'b1;
            cls      = CLS_W'(i);
            tgt_el   = EL_W'(1);
         end
      end
      for (int i = 0; i < NCLS; i++) begin
         if (phys_take[i]) begin
            any_take = 1'b1;
            is_virt  = 1'b0;
            cls      = CLS_W'(i);
            tgt_el   = phys_to_el2[i] ? EL_W'(2) : EL_W'(1);
         end
      end
   end
endmodule

// File: rtl/vint_router.sv
module vint_router #(
   parameter int NCLS  = vint_route_pkg::CLASS_COUNT,
   parameter int EL_W  = vint_route_pkg::EL_BITS,
   localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EL_W-1:0]  cur_el,
   input  logic [NCLS-1:0]  pstate_mask,
   input  logic [NCLS-1:0]  route_en,
   input  logic             host_mode,
   input  logic             vhe_en,
   input  logic [NCLS-1:0]  phys_pend,
   input  logic [NCLS-1:0]  virt_sw,
   input  logic [NCLS-1:0]  virt_ext,
   output logic             take_o,
   output logic             take_virt_o,
   output logic [CLS_W-1:0] take_cls_o,
   output logic [EL_W-1:0]  take_el_o
);
   if (EL_W < 2) begin : g_bad_el_w
      $error("vint_router: EL_W must be at least 2");
   end
   if (NCLS < 1 || NCLS > 4) begin : g_bad_ncls
      $error("vint_router: NCLS must be 1 to 4");
   end

   logic            host_ovr;
   logic [NCLS-1:0] vpend;
   logic [NCLS-1:0] phys_take;
   logic [NCLS-1:0] phys_to_el2;
   logic [NCLS-1:0] virt_take;

   assign host_ovr = host_mode & vhe_en & (cur_el == '0);
   assign vpend    = virt_sw | virt_ext;

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      vint_class_eval #(.EL_W(EL_W)) u_eval (
         .cur_el      (cur_el),
         .mask_bit    (pstate_mask[c]),
         .route_bit   (route_en[c]),
         .host_ovr    (host_ovr),
         .phys        (phys_pend[c]),
         .vpend       (vpend[c]),
         .phys_take   (phys_take[c]),
         .phys_to_el2 (phys_to_el2[c]),
         .virt_take   (virt_take[c])
      );
   end

   logic             nxt_take;
   logic             nxt_virt;
   logic [CLS_W-1:0] nxt_cls;
   logic [EL_W-1:0]  nxt_el;

   vint_pick #(.NCLS(NCLS), .EL_W(EL_W)) u_pick (
      .phys_take   (phys_take),
      .phys_to_el2 (phys_to_el2),
      .virt_take   (virt_take),
      .any_take    (nxt_take),
      .is_virt     (nxt_virt),
      .cls         (nxt_cls),
      .tgt_el      (nxt_el)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_o      <= 1'b0;
         take_virt_o <= 1'b0;
         take_cls_o  <= '0;
         take_el_o   <= '0;
      end else begin
         take_o      <= nxt_take;
         take_virt_o <= nxt_virt;
         take_cls_o  <= nxt_cls;
         take_el_o   <= nxt_el;
      end
   end
endmodule

// File: rtl/vint_router_chk.sv
module vint_router_chk #(
   parameter int NCLS  = 3,
   parameter int EL_W  = 2,
   localparam int CLS_W = (NCLS > 1) ? $clog2(NCLS) : 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EL_W-1:0]  cur_el,
   input logic [NCLS-1:0]  pstate_mask,
   input logic [NCLS-1:0]  route_en,
   input logic             host_mode,
   input logic             vhe_en,
   input logic [NCLS-1:0]  phys_pend,
   input logic [NCLS-1:0]  virt_sw,
   input logic [NCLS-1:0]  virt_ext,
   input logic             take_o,
   input logic             take_virt_o,
   input logic [CLS_W-1:0] take_cls_o,
   input logic [EL_W-1:0]  take_el_o
);
   logic [EL_W-1:0] p_el;
   logic [NCLS-1:0] p_mask;
   logic [NCLS-1:0] p_route;
   logic            p_hovr;
   logic            p_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_el    <= '0;
         p_mask  <= '0;
         p_route <= '0;
         p_hovr  <= 1'b0;
         p_any   <= 1'b0;
      end else begin
         p_el    <= cur_el;
         p_mask  <= pstate_mask;
         p_route <= route_en;
         p_hovr  <= host_mode & vhe_en & (cur_el == '0);
         p_any   <= |(phys_pend | virt_sw | virt_ext);
      end
   end

   // R1: nothing pending means no strobe
   a_r1_idle_no_take: assert property (@(posedge clk) disable iff (!rst_n)
      !p_any |-> !take_o);
   // R1: class code stays in its legal range
   a_r1_cls_legal: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (int'(take_cls_o) < NCLS));
   // R3: virtual only below EL2, delivered to EL1
   a_r3_virt_low_el: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_virt_o) |-> (p_el <= EL_W'(1) && take_el_o == EL_W'(1)));
   // R4: virtual needs routing set and mask clear
   a_r4_virt_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_virt_o) |-> (p_route[take_cls_o] && !p_mask[take_cls_o]));
   // R6: physical at EL2 obeys the mask
   a_r6_el2_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !take_virt_o && p_el == EL_W'(2)) |-> !p_mask[take_cls_o]);
   // R8: host mode at EL0 sends physical to EL2 and never takes virtual
   a_r8_host_override: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && p_hovr) |-> (!take_virt_o && take_el_o == EL_W'(2)));
endmodule

bind vint_router vint_router_chk #(.NCLS(NCLS), .EL_W(EL_W)) u_chk (.*);

// File: tb/vint_router_tb.sv
`timescale 1ns/1ps
module vint_router_tb;
   localparam int NV = 19;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cur_el = '0;
   logic [2:0] pstate_mask = '0;
   logic [2:0] route_en = '0;
   logic       host_mode = 1'b0;
   logic       vhe_en = 1'b0;
   logic [2:0] phys_pend = '0;
   logic [2:0] virt_sw = '0;
   logic [2:0] virt_ext = '0;
   logic       take_o;
   logic       take_virt_o;
   logic [1:0] take_cls_o;
   logic [1:0] take_el_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vint_router u_dut (
      .clk(clk), .rst_n(rst_n), .cur_el(cur_el), .pstate_mask(pstate_mask),
      .route_en(route_en), .host_mode(host_mode), .vhe_en(vhe_en),
      .phys_pend(phys_pend), .virt_sw(virt_sw), .virt_ext(virt_ext),
      .take_o(take_o), .take_virt_o(take_virt_o), .take_cls_o(take_cls_o),
      .take_el_o(take_el_o)
   );

   // fields: el[24:23] mask[22:20] route[19:17] host[16] vhe[15] phys[14:12]
   //         sw[11:9] ext[8:6] | take[5] virt[4] cls[3:2] tgt[1:0]
   localparam logic [24:0] VEC [NV] = '{
      {2'd1,3'b000,3'b000,1'b0,1'b0,3'b001,3'b000,3'b000, 1'b1,1'b0,2'd0,2'd1}, // R7
      {2'd1,3'b001,3'b000,1'b0,1'b0,3'b001,3'b000,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R7
      {2'd1,3'b001,3'b001,1'b0,1'b0,3'b001,3'b000,3'b000, 1'b1,1'b0,2'd0,2'd2}, // R5
      {2'd1,3'b001,3'b001,1'b0,1'b0,3'b000,3'b001,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R4
      {2'd1,3'b000,3'b001,1'b0,1'b0,3'b000,3'b001,3'b000, 1'b1,1'b1,2'd0,2'd1}, // R2
      {2'd0,3'b000,3'b000,1'b0,1'b0,3'b000,3'b001,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R4
      {2'd2,3'b000,3'b001,1'b0,1'b0,3'b000,3'b001,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R3
      {2'd2,3'b000,3'b001,1'b0,1'b0,3'b001,3'b000,3'b000, 1'b1,1'b0,2'd0,2'd2}, // R6
      {2'd2,3'b001,3'b001,1'b0,1'b0,3'b001,3'b000,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R6
      {2'd3,3'b000,3'b111,1'b0,1'b0,3'b111,3'b111,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R6
      {2'd0,3'b111,3'b000,1'b1,1'b1,3'b010,3'b000,3'b000, 1'b1,1'b0,2'd1,2'd2}, // R8
      {2'd0,3'b000,3'b111,1'b1,1'b1,3'b000,3'b111,3'b000, 1'b0,1'b0,2'd0,2'd0}, // R8
      {2'd0,3'b000,3'b000,1'b1,1'b0,3'b010,3'b000,3'b000, 1'b1,1'b0,2'd1,2'd1}, // R8
      {2'd1,3'b000,3'b111,1'b0,1'b0,3'b001,3'b000,3'b110, 1'b1,1'b0,2'd0,2'd2}, // R9
      {2'd1,3'b000,3'b111,1'b0,1'b0,3'b000,3'b000,3'b011, 1'b1,1'b1,2'd1,2'd1}, // R10
      {2'd1,3'b000,3'b000,1'b0,1'b0,3'b111,3'b000,3'b000, 1'b1,1'b0,2'd2,2'd1}, // R10
      {2'd1,3'b100,3'b000,1'b0,1'b0,3'b110,3'b000,3'b000, 1'b1,1'b0,2'd1,2'd1}, // R10
      {2'd1,3'b000,3'b100,1'b0,1'b0,3'b000,3'b000,3'b100, 1'b1,1'b1,2'd2,2'd1}, // R2
      {2'd2,3'b000,3'b000,1'b0,1'b0,3'b111,3'b000,3'b000, 1'b0,1'b0,2'd0,2'd0}  // R7
   };
   string vreq [NV] = '{"R7","R7","R5","R4","R2","R4","R3","R6","R6","R6",
                        "R8","R8","R8","R9","R10","R10","R10","R2","R7"};

   task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic drive(input logic [24:0] v);
      cur_el      = v[24:23];
      pstate_mask = v[22:20];
      route_en    = v[19:17];
      host_mode   = v[16];
      vhe_en      = v[15];
      phys_pend   = v[14:12];
      virt_sw     = v[11:9];
      virt_ext    = v[8:6];
   endtask

   function automatic logic [5:0] outs();
      return {take_o, take_virt_o, take_cls_o, take_el_o};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      check("R11", outs(), 6'b0);
      rst_n = 1'b1;
      // table walk: drive at falling edge, result due after the next rising edge
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VEC[i]);
         @(negedge clk);
         check(vreq[i], outs(), {VEC[i][5:0]});
         drive(25'd0);
      end
      // R1: strobe falls one cycle after inputs go idle
      @(negedge clk);
      drive(VEC[0]);
      @(negedge clk);
      check("R1", outs(), 6'b100001);
      drive(25'd0);
      @(negedge clk);
      check("R1", outs(), 6'b000000);
      // R11: asynchronous reset clears a live strobe without a clock edge
      drive(VEC[15]);
      @(negedge clk);
      check("R10", outs(), 6'b101001);
      #1 rst_n = 1'b0;
      #1 check("R11", outs(), 6'b000000);
      @(negedge clk);
      rst_n = 1'b1;
      drive(25'd0);
      @(negedge clk);
      check("R1", outs(), 6'b000000);
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule